// File: doc/BRIEF.md
# Pipelined Processor Bus Cycle Controller

This controller is the external-bus side of a simple processor. Internal logic hands it read and write requests over a valid/ready handshake. It runs each request as a bus cycle: it drives the address, the direction and a strobe, drives write data, waits for an active-low ready from the addressed device, and then captures read data or reports that a write is complete. A one-clock `done` pulse marks the end of every cycle.

Each bus state lasts two clocks, called phase 1 and phase 2, and the `bus_ph2` output marks the second one. The block samples its inputs only at the end of phase 2. Address timing is chosen cycle by cycle. A cycle that starts from idle, or that is not overlapped, uses plain timing: the strobe is asserted in its first state. If the device asserts the active-low next-address input during a waiting state while another request is pending, the controller accepts that request at once. It then puts the new address and direction on the bus, with the strobe, while the current cycle is still waiting for ready. A write's data stays driven through phase 1 of the state after its acknowledge, which gives the device hold time. A new cycle may follow with no idle state in between.

Top module: `pbus_ctrl`

## Requirements
- R1: After reset the bus is idle: `ads_n`=1, `dat_oe`=0, `done`=0, `req_ready`=0 and `bus_ph2`=0. `bus_ph2` then toggles on every clock.
- R2: A cycle that starts without overlap puts the request's address and direction on the bus and holds `ads_n` low for exactly its first state, which is both phases. This holds even if `nxa_n` was asserted earlier.
- R3: Ready is first sampled at the end of a cycle's second state. When `rdy_n`=0 there, the cycle ends and `done` is 1 for exactly the one clock that follows.
- R4: While `rdy_n` is 1 at a sampling point, one wait state is added and ready is sampled again at its end. There is no limit on the number of wait states.
- R5: At the acknowledge of a read, `dat_in` is captured into `rd_data`. `rd_data` keeps that value until the next read is acknowledged.
- R6: A write drives `dat_oe`=1 with its data from phase 2 of its first state as the active cycle until its acknowledge. It keeps driving through phase 1 of the following state and releases `dat_oe` only after that phase, unless the next cycle is itself a write.
- R7: If `nxa_n`=0 and `rdy_n`=1 at a sampling point and a request is valid, that request is accepted there. In the next state `bus_addr`/`bus_write` show the new cycle and `ads_n` is low for that one state. After the current acknowledge the new cycle becomes active, and ready is sampled at the end of its first state as the active cycle.
- R8: `nxa_n` has no effect in a cycle's first state, at a sampling point where `rdy_n`=0, or when no request is valid. The next cycle then uses plain timing.
- R9: When a request is valid at an acknowledge, the next cycle starts in the very next state with no idle state, including directly after a write.
- R10: When no request is pending at an acknowledge, the controller returns to idle. In phase 2 of every idle state `ads_n`=1 and `dat_oe`=0.
- R11: `req_ready` is only ever 1 in phase 2 of an idle state, or of a sampling state with no overlapped request, and a request is taken exactly when `req_valid` and `req_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, two clocks per bus state |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Internal request present |
| req_ready | output | 1 | Request is taken this clock |
| req_addr | input | AW | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW | Write data of the request |
| done | output | 1 | One-clock pulse when a cycle is acknowledged |
| rd_data | output | DW | Data captured at the last read acknowledge |
| bus_ph2 | output | 1 | 1 during phase 2 of a bus state |
| bus_addr | output | AW | Address on the external bus |
| bus_write | output | 1 | Direction on the external bus |
| ads_n | output | 1 | Active-low address strobe |
| dat_out | output | DW | Write data to the bus |
| dat_oe | output | 1 | Data driver enable |
| dat_in | input | DW | Data from the bus |
| rdy_n | input | 1 | Active-low cycle acknowledge |
| nxa_n | input | 1 | Active-low request for early next address |

## Verification
The bench runs cycles with zero, a few and forty wait states. A design that sampled ready in the first state, or that capped the wait count, would show `done` at the wrong clock. It asserts next-address in a cycle's first state, in the acknowledge state and with nothing queued. A design that honoured it there would strobe an early address or swallow a request. Overlapped read-to-write and write-to-write pairs check that the bus address switches one state before the acknowledge while the write data stays with the older cycle. Back-to-back writes check that the hold phase carries the old data and is not cut off or stretched.

// File: rtl/pbus_ctrl.sv
module pbus_ctrl #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic          bus_ph2,
  output logic [AW-1:0] bus_addr,
  output logic          bus_write,
  output logic          ads_n,
  output logic [DW-1:0] dat_out,
  output logic          dat_oe,
  input  logic [DW-1:0] dat_in,
  input  logic          rdy_n,
  input  logic          nxa_n
);
  localparam logic [1:0] S_IDLE = 2'd0, S_ADR = 2'd1, S_DAT = 2'd2, S_OVL = 2'd3;

  logic [1:0]    st;
  logic          ph, first, pstb, hold;
  logic [AW-1:0] cur_a, nxt_a;
  logic [DW-1:0] cur_d, nxt_d, hold_d;
  logic          cur_w, nxt_w;

  wire ack  = ph & (st == S_DAT | st == S_OVL) & ~rdy_n;
  assign req_ready = ph & (st == S_IDLE | (st == S_DAT & (~rdy_n | ~nxa_n)));
  wire take = req_valid & req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= 1'b0; first <= 1'b0; pstb <= 1'b0; hold <= 1'b0;
      hold_d <= '0; cur_a <= '0; cur_w <= 1'b0; cur_d <= '0;
      nxt_a <= '0; nxt_w <= 1'b0; nxt_d <= '0; done <= 1'b0; rd_data <= '0;
    end else begin
      ph   <= ~ph;
      done <= ack;
      if (!ph) hold <= 1'b0;
      if (ack) begin
        if (cur_w) begin
          hold   <= 1'b1;
          hold_d <= cur_d;
        end else begin
          rd_data <= dat_in;
        end
      end
      if (ph) begin
        first <= 1'b0;
        pstb  <= 1'b0;
        case (st)
          S_IDLE: if (take) begin
            cur_a <= req_addr; cur_w <= req_write; cur_d <= req_wdata;
            first <= 1'b1; st <= S_ADR;
          end
          S_ADR: st <= S_DAT;
          S_DAT: begin
            if (!rdy_n) begin
              if (take) begin
                cur_a <= req_addr; cur_w <= req_write; cur_d <= req_wdata;
                first <= 1'b1; st <= S_ADR;
              end else begin
                st <= S_IDLE;
              end
            end else if (take) begin
              nxt_a <= req_addr; nxt_w <= req_write; nxt_d <= req_wdata;
              pstb <= 1'b1; st <= S_OVL;
            end
          end
          default: if (!rdy_n) begin
            cur_a <= nxt_a; cur_w <= nxt_w; cur_d <= nxt_d;
            first <= 1'b1; st <= S_DAT;
          end
        endcase
      end
    end
  end

  assign bus_ph2   = ph;
  assign bus_addr  = (st == S_OVL) ? nxt_a : cur_a;
  assign bus_write = (st == S_OVL) ? nxt_w : cur_w;
  assign ads_n     = ~((st == S_ADR) | pstb);
  assign dat_oe    = hold | ((st != S_IDLE) & cur_w & ~(first & ~ph));
  assign dat_out   = hold ? hold_d : cur_d;
endmodule

// File: rtl/pbus_ctrl_chk.sv
module pbus_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ph,
  input logic [1:0] st,
  input logic       ads_n,
  input logic       dat_oe,
  input logic       done,
  input logic       req_ready
);
  assert_strobe_whole_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ads_n && !ph) |=> !ads_n);
  assert_strobe_one_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ads_n && ph) |=> ads_n);
  assert_release_after_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dat_oe) |-> ph);
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 && ph) |-> (ads_n && !dat_oe));
  assert_take_at_state_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> ph);
endmodule

bind pbus_ctrl pbus_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ph(ph), .st(st), .ads_n(ads_n),
  .dat_oe(dat_oe), .done(done), .req_ready(req_ready)
);

// File: tb/pbus_ctrl_bench.sv
`timescale 1ns/1ps
module pbus_ctrl_bench;
  typedef struct {
    logic [31:0] a;
    logic        w;
    logic [31:0] d;
    int          waits;
    int          na_at;
  } txn_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rdy_n = 1'b1, nxa_n = 1'b1;
  logic [31:0] req_addr = '0, req_wdata = '0, dat_in = '0;
  logic req_ready, done, bus_ph2, bus_write, ads_n, dat_oe;
  logic [31:0] rd_data, bus_addr, dat_out;

  always #2.5 clk = ~clk;

  pbus_ctrl u_pbus_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .done(done), .rd_data(rd_data), .bus_ph2(bus_ph2), .bus_addr(bus_addr),
    .bus_write(bus_write), .ads_n(ads_n), .dat_out(dat_out), .dat_oe(dat_oe),
    .dat_in(dat_in), .rdy_n(rdy_n), .nxa_n(nxa_n)
  );

  int total = 0, bad = 0, pushed = 0, dones = 0, cyc = 0;
  bit finished = 0;
  txn_t q[$];

  // behavioural reference state
  bit   started = 0, m_ph = 0, m_act = 0, m_first = 0, m_nstb = 0, m_hn = 0, m_hold = 0, m_done = 0;
  int   k = 0;
  txn_t m_cur = '{0, 0, 0, 0, -1}, m_nxt = '{0, 0, 0, 0, -1};
  logic [31:0] m_hd = '0, m_rd = '0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  function automatic bit rr_e();
    return m_ph && (!m_act || (k >= 1 && !m_hn && (!rdy_n || !nxa_n)));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      started = 0; m_ph = 0; m_act = 0; m_first = 0; m_nstb = 0; m_hn = 0;
      m_hold = 0; m_done = 0; k = 0; m_cur = '{0, 0, 0, 0, -1}; m_hd = '0; m_rd = '0;
    end else begin
      bit acc;
      txn_t t;
      t = '{0, 0, 0, 0, -1};
      started = 1;
      acc = req_valid && rr_e();
      if (acc) t = q.pop_front();
      m_done = 0;
      if (!m_ph) m_hold = 0;
      if (m_ph) begin
        m_nstb = 0;
        if (!m_act) begin
          m_first = 0;
          if (acc) begin m_cur = t; m_act = 1; k = 0; m_first = 1; end
        end else if (k >= 1 && !rdy_n) begin
          m_done = 1;
          if (m_cur.w) begin m_hold = 1; m_hd = m_cur.d; end
          else m_rd = dat_in;
          if (m_hn) begin m_cur = m_nxt; m_hn = 0; k = 1; m_first = 1; end
          else if (acc) begin m_cur = t; k = 0; m_first = 1; end
          else begin m_act = 0; m_first = 0; end
        end else begin
          if (acc) begin m_nxt = t; m_hn = 1; m_nstb = 1; end
          k++;
          m_first = 0;
        end
      end
      m_ph = !m_ph;
    end
  end

  // compare every clock, then drive the device side and the request side
  always @(negedge clk) begin
    if (rst_n && started) begin
      bit oe_e;
      oe_e = m_hold || (m_act && m_cur.w && !(m_first && !m_ph));
      chk("R1 bus_ph2", 64'(bus_ph2), 64'(m_ph));
      chk("R2,R7 ads_n", 64'(ads_n), 64'(!(m_act && (k == 0 || m_nstb))));
      chk("R7,R8 bus_addr", 64'(bus_addr), 64'(m_hn ? m_nxt.a : m_cur.a));
      chk("R7,R8 bus_write", 64'(bus_write), 64'(m_hn ? m_nxt.w : m_cur.w));
      chk("R6,R9 dat_oe", 64'(dat_oe), 64'(oe_e));
      if (oe_e) chk("R6,R9 dat_out", 64'(dat_out), 64'(m_hold ? m_hd : m_cur.d));
      chk("R3,R4 done", 64'(done), 64'(m_done));
      chk("R5 rd_data", 64'(rd_data), 64'(m_rd));
      chk("R11 req_ready", 64'(req_ready), 64'(rr_e()));
      if (done) dones++;
    end
    rdy_n  = !(m_act && k >= 1 + m_cur.waits);
    nxa_n  = !(m_act && k == m_cur.na_at);
    dat_in = {m_cur.a[15:0], 16'(k)};
    req_valid = q.size() > 0;
    if (q.size() > 0) begin
      req_addr = q[0].a; req_write = q[0].w; req_wdata = q[0].d;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      finish_run();
    end
  end

  task automatic push(input logic [31:0] a, input logic w, input int waits, input int na_at);
    q.push_back('{a, w, a ^ 32'h5A5A_0F0F, waits, na_at});
    pushed++;
  endtask

  task automatic settle();
    @(negedge clk);
    while (q.size() > 0 || m_act) @(negedge clk);
    repeat (4) @(negedge clk);
    if (bus_ph2) @(negedge clk);
    @(negedge clk);
    // phase 2 of an idle state: strobe and driver inactive
    chk("R10 idle ads_n", 64'(ads_n), 64'(1));
    chk("R10 idle dat_oe", 64'(dat_oe), 64'(0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 ads_n", 64'(ads_n), 64'(1));
    chk("R1 dat_oe", 64'(dat_oe), 64'(0));
    chk("R1 done", 64'(done), 64'(0));
    chk("R1 req_ready", 64'(req_ready), 64'(0));
    chk("R1 bus_ph2", 64'(bus_ph2), 64'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    push(32'h0000_1000, 0, 0, -1);            // R2 R3 R5 minimal read
    settle();
    push(32'h0000_2004, 1, 3, -1);            // R4 R6 write with waits
    settle();
    push(32'h0000_3000, 1, 0, -1);            // R9 back to back, no idle
    push(32'h0000_3004, 1, 1, -1);
    push(32'h0000_3008, 0, 0, -1);
    push(32'h0000_300C, 1, 0, -1);
    settle();
    push(32'h0000_4000, 0, 3, 1);             // R7 overlapped chain
    push(32'h0000_4004, 1, 2, 2);
    push(32'h0000_4008, 0, 0, -1);
    settle();
    push(32'h0000_5000, 0, 1, 0);             // R8 next-address in first state
    push(32'h0000_5004, 1, 0, -1);
    settle();
    push(32'h0000_6000, 0, 1, 2);             // R8 next-address with ready
    push(32'h0000_6004, 1, 0, -1);
    settle();
    push(32'h0000_7000, 0, 2, 1);             // R8 next-address, nothing pending
    settle();
    push(32'h0000_8000, 0, 40, -1);           // R4 long wait
    settle();
    push(32'h0000_9000, 1, 1, 1);             // R6 R7 overlapped write pair
    push(32'h0000_9004, 1, 0, -1);
    settle();
    chk("R3 done count", 64'(dones), 64'(pushed));
    finish_run();
  end
endmodule